// File: doc/BRIEF.md
# Programmable Duty Pulse Tone Generator

This block is a single square-wave audio voice clocked by the CPU clock. Software programs it through three write-only byte registers, each selected by its own write strobe. The three registers hold the control byte (direct-mode flag, duty code and volume), the low byte of a 12-bit period, and the enable flag together with the upper four period bits. Address decoding sits outside the block.

A 12-bit down counter produces one step pulse every F+1 cycles, where F is the programmed period. A 16-position sequencer advances on each step pulse. The 4-bit output is either zero or the programmed volume, so one full waveform lasts 16·(F+1) cycles. Setting the direct-mode flag bypasses the sequencer. The volume field then drives the output continuously, which lets software stream 4-bit samples by writing the control byte. Mixing and conversion to analog happen downstream.

Top module: `pulse_tone_gen`

## Requirements
- R1: Control byte fields: bit 7 selects direct mode, bits 6..4 hold the duty code D, and bits 3..0 hold the volume V. The output is only ever 0 or V.
- R2: The period F is 12 bits wide. Bits 7..0 come from the period-low write and bits 11..8 come from bits 3..0 of the enable/period-high write.
- R3: Bit 7 of the enable/period-high write enables the channel. While it is 0, the output is 0, starting the cycle after the write.
- R4: While enabled, the counter decrements every clock. On reaching zero it reloads F and advances the sequencer. Each sequencer position therefore lasts F+1 cycles, and one waveform lasts 16·(F+1) cycles.
- R5: The step index counts down from 15 and wraps from 0 to 15. Outside direct mode, the output is V while the index is at most D. This gives a high time of (D+1)·(F+1) cycles per waveform.
- R6: In direct mode with the channel enabled, the output is V continuously. A new control write changes the output in the cycle after the write.
- R7: While disabled, the step index is held at 15 and the counter at 0. After enabling, the first cycle steps immediately, so the first nonzero output appears 1+(14−D)·(F+1) cycles after the enable write.
- R8: Reset is asynchronous and active low. It clears all registers, so after reset the output is 0 and F, D, V and the mode flag are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctrl_we_i | input | 1 | Write strobe for the control byte |
| per_lo_we_i | input | 1 | Write strobe for the period low byte |
| per_hi_we_i | input | 1 | Write strobe for the enable and period high bits |
| wdata_i | input | 8 | Write data |
| tone_o | output | 4 | Channel output level |

## Verification
A write is captured at the rising edge where its strobe is high. The output is derived combinationally from registered state, so it reflects the write one cycle later. The bench drives at the falling edge and samples at the falling edge that follows the capturing edge. Waveform period and high time are measured from rising output edges in steady state and compared with 16·(F+1) and (D+1)·(F+1). The start-up delay after enabling is counted from the first falling edge after the enable write and compared with 1+(14−D)·(F+1).

// File: rtl/pulse_tone_pkg.sv
package pulse_tone_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned PERIOD_W = 12;
  localparam int unsigned STEP_W   = 4;
  localparam int unsigned DUTY_W   = 3;
  localparam int unsigned VOL_W    = 4;

  typedef struct packed {
    logic              direct;
    logic [DUTY_W-1:0] duty;
    logic [VOL_W-1:0]  vol;
  } tone_ctrl_t;
endpackage

// File: rtl/pulse_regs.sv
module pulse_regs
  import pulse_tone_pkg::*;
#(
  parameter int unsigned PW = PERIOD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic              per_lo_we_i,
  input  logic              per_hi_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output tone_ctrl_t        ctrl_o,
  output logic [PW-1:0]     period_o,
  output logic              en_o
);
  localparam int unsigned HI_W = PW - DATA_W;

  tone_ctrl_t        ctrl_q;
  logic [DATA_W-1:0] lo_q;
  logic [HI_W-1:0]   hi_q;
  logic              en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      en_q   <= 1'b0;
    end else begin
      if (ctrl_we_i)   ctrl_q <= tone_ctrl_t'(wdata_i);
      if (per_lo_we_i) lo_q   <= wdata_i;
      if (per_hi_we_i) begin
        hi_q <= wdata_i[HI_W-1:0];
        en_q <= wdata_i[DATA_W-1];
      end
    end
  end

  assign ctrl_o   = ctrl_q;
  assign period_o = {hi_q, lo_q};
  assign en_o     = en_q;
endmodule

// File: rtl/pulse_divider.sv
module pulse_divider #(
  parameter int unsigned PW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [PW-1:0] period_i,
  output logic          tick_o
);
  logic [PW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == '0);

  // disabled: park at zero so the first enabled cycle steps at once
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (tick_o)  cnt_q <= period_i;
    else              cnt_q <= cnt_q - 1'b1;
  end

  // R4
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && cnt_q == '0) |=> (cnt_q == $past(period_i)));
  // R4
  decrement_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/pulse_sequencer.sv
module pulse_sequencer #(
  parameter int unsigned SW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          tick_i,
  output logic [SW-1:0] step_o
);
  localparam logic [SW-1:0] STEP_START = '1;

  logic [SW-1:0] step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     step_q <= STEP_START;
    else if (!en_i)  step_q <= STEP_START;
    else if (tick_i) step_q <= step_q - 1'b1;
  end

  assign step_o = step_q;

  // R7
  park_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (step_q == STEP_START));
  // R5
  advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (step_q == $past(step_q) - 1'b1));
  // R5
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i) |=> $stable(step_q));
endmodule

// File: rtl/pulse_tone_gen.sv
module pulse_tone_gen
  import pulse_tone_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic              per_lo_we_i,
  input  logic              per_hi_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [VOL_W-1:0]  tone_o
);
  tone_ctrl_t          ctrl;
  logic [PERIOD_W-1:0] period;
  logic                en;
  logic                tick;
  logic [STEP_W-1:0]   step;

  pulse_regs #(.PW(PERIOD_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctrl_we_i   (ctrl_we_i),
    .per_lo_we_i (per_lo_we_i),
    .per_hi_we_i (per_hi_we_i),
    .wdata_i     (wdata_i),
    .ctrl_o      (ctrl),
    .period_o    (period),
    .en_o        (en)
  );

  pulse_divider #(.PW(PERIOD_W)) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en),
    .period_i (period),
    .tick_o   (tick)
  );

  pulse_sequencer #(.SW(STEP_W)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en),
    .tick_i (tick),
    .step_o (step)
  );

  logic duty_on;
  assign duty_on = (step <= STEP_W'(ctrl.duty));

  always_comb begin
    if (!en)                        tone_o = '0;
    else if (ctrl.direct || duty_on) tone_o = ctrl.vol;
    else                            tone_o = '0;
  end

  // R1
  level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tone_o == '0) || (tone_o == ctrl.vol));
  // R3
  disable_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_hi_we_i && !wdata_i[DATA_W-1]) |=> (tone_o == '0));
  // R6
  direct_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && wdata_i[DATA_W-1] && !per_hi_we_i && en)
      |=> (tone_o == $past(wdata_i[VOL_W-1:0])));
endmodule

// File: tb/pulse_tone_gen_bench.sv
module pulse_tone_gen_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 7;
  localparam int  WATCHDOG = 150000;

  // {F, D, V, expected high cycles, expected period cycles}
  localparam logic [11:0] VF  [NVEC] = '{12'd0, 12'd1, 12'd2, 12'd5, 12'd0, 12'd9, 12'h123};
  localparam logic [2:0]  VD  [NVEC] = '{3'd0, 3'd7, 3'd3, 3'd1, 3'd7, 3'd5, 3'd2};
  localparam logic [3:0]  VV  [NVEC] = '{4'hF, 4'h1, 4'h7, 4'hC, 4'h5, 4'h9, 4'h3};
  localparam int          VHI [NVEC] = '{1, 16, 12, 12, 8, 60, 876};
  localparam int          VPER[NVEC] = '{16, 32, 48, 96, 16, 160, 4672};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctrl_we = 1'b0, lo_we = 1'b0, hi_we = 1'b0;
  logic [7:0] wdata = '0;
  logic [3:0] tone;

  int n_run = 0, n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  pulse_tone_gen u_pulse_tone_gen (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_we_i(ctrl_we), .per_lo_we_i(lo_we),
    .per_hi_we_i(hi_we), .wdata_i(wdata), .tone_o(tone)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // sel: 0 ctrl, 1 period low, 2 enable/period high
  task automatic wr(input int sel, input logic [7:0] d);
    @(negedge clk);
    ctrl_we = (sel == 0); lo_we = (sel == 1); hi_we = (sel == 2); wdata = d;
    @(negedge clk);
    ctrl_we = 1'b0; lo_we = 1'b0; hi_we = 1'b0;
  endtask

  task automatic measure(input logic [3:0] v, output int hi, output int per, output int bad);
    logic [3:0] prev, c;
    bit in_high;
    hi = 0; per = 0; bad = 0;
    prev = tone;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      c = tone;
      if (prev == 0 && c != 0) break;
      prev = c;
    end
    if (c != v) bad++;
    hi = 1; per = 1; in_high = 1'b1;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      c = tone;
      if (c != 0 && !in_high) break;
      if (c == 0) in_high = 1'b0;
      else if (in_high) begin
        hi++;
        if (c != v) bad++;
      end
      per++;
    end
  endtask

  initial begin : watchdog
    while (cyc < WATCHDOG && !done) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual %0d expected <%0d cycles", cyc, WATCHDOG);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    int hi, per, bad, z;
    repeat (3) @(negedge clk);
    // R8: output held at 0 in reset
    chk("R8 reset output", tone, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 output after release", tone, 0);

    // R8: period cleared by reset -> F=0 gives 16-cycle waveform
    wr(0, {1'b0, 3'd0, 4'hE});
    wr(2, 8'h80);
    measure(4'hE, hi, per, bad);
    chk("R8 cleared period length", per, 16);
    chk("R8 cleared period high", hi, 1);

    // R1 R2 R4 R5: vector table
    for (int k = 0; k < NVEC; k++) begin
      wr(2, 8'h00);
      wr(0, {1'b0, VD[k], VV[k]});
      wr(1, VF[k][7:0]);
      wr(2, {4'b1000, VF[k][11:8]});
      measure(VV[k], hi, per, bad);
      chk($sformatf("R4 period vec%0d", k), per, VPER[k]);
      chk($sformatf("R5 high time vec%0d", k), hi, VHI[k]);
      chk($sformatf("R1 level vec%0d", k), bad, 0);
    end

    // R7: start-up delay after enable, F=1 D=3 -> 1+11*2 = 23
    wr(2, 8'h00);
    wr(0, {1'b0, 3'd3, 4'hA});
    wr(1, 8'd1);
    wr(2, 8'h80);
    z = 0;
    for (int i = 0; i < 200 && tone == 0; i++) begin
      z++;
      @(negedge clk);
    end
    chk("R7 zero run after enable", z, 23);
    chk("R7 first level", tone, 4'hA);

    // R6: direct mode follows volume
    wr(0, {1'b1, 3'd0, 4'h9});
    bad = 0;
    for (int i = 0; i < 40; i++) begin
      if (tone != 4'h9) bad++;
      @(negedge clk);
    end
    chk("R6 direct constant", bad, 0);
    wr(0, {1'b1, 3'd0, 4'h5});
    chk("R6 direct new sample", tone, 5);
    wr(0, {1'b1, 3'd7, 4'h0});
    chk("R6 direct zero sample", tone, 0);

    // R3: disable silences next cycle, even in direct mode
    wr(0, {1'b1, 3'd0, 4'hB});
    chk("R3 direct before disable", tone, 4'hB);
    wr(2, 8'h01);
    chk("R3 disabled output", tone, 0);
    bad = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (tone != 0) bad++;
    end
    chk("R3 stays silent", bad, 0);

    // R8: asynchronous reset mid-run
    wr(2, 8'h80);
    chk("R8 enabled before reset", tone, 4'hB);
    #(CLK_PERIOD/4) rst_n = 1'b0;
    #1;
    chk("R8 async reset output", tone, 0);
    @(negedge clk);
    rst_n = 1'b1;
    wr(2, 8'h80);
    chk("R8 ctrl cleared by reset", tone, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule